// File: doc/BRIEF.md
# Banked GPIO Register Controller

A memory-mapped controller for general-purpose pins, parameterised up to 160 pins and organised as banks of 32. Software reaches it over a plain 32-bit register bus made of a byte address, a write strobe, write data and registered read data. Each pin has a direction bit and an output latch. The latch can be written whole, or changed bit by bit through a write-one-to-set register and a write-one-to-clear register. With those two registers, several agents can drive different pins of the same bank without a read-modify-write sequence.

The pad side has three vectors: the pad levels coming in, an output-enable vector and an output-value vector. Every incoming pad level passes through a two-flop synchronizer before software can read it. The input register returns this synchronized level for every pin, including pins that the controller itself is driving. A read that follows a write to the output latch can therefore still show the old pad level for a few cycles.

Each bank owns a 0x28-byte window. The window of bank k starts at byte 0x10 + 0x28·k. Inside a window the words are laid out as follows:

| Offset | Register |
|--------|----------|
| 0x00 | direction |
| 0x04 | output latch |
| 0x08 | set |
| 0x0C | clear |
| 0x10 | input |

Top module: `gpio_bank_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it, `pad_oe`, `pad_out` and `bus_rdata` are all zero. After reset, every direction bit is 1 and every latch bit is 0.
- R2: A write to the direction word (window offset 0x00) replaces the bank's direction bits. In this word, bit 1 means input and bit 0 means output, so `pad_oe` for a pin is the inverse of its direction bit. The new value shows on `pad_oe` after the writing clock edge.
- R3: A write to the set word (offset 0x08) sets each latch bit whose mask bit is 1. Latch bits whose mask bit is 0 keep their value.
- R4: A write to the clear word (offset 0x0C) clears each latch bit whose mask bit is 1. Latch bits whose mask bit is 0 keep their value.
- R5: A write to the output word (offset 0x04) replaces the whole latch. `pad_out` always shows the latch, whatever the direction.
- R6: The input word (offset 0x10) returns the pad level after two synchronizing flops. This holds for pins driven as outputs as well. A level present before clock edge e appears in `bus_rdata` after edge e+2 when the address is held on that word. A read issued on the cycle the pad changes returns the old level.
- R7: Reads return zero and writes change nothing for any of these addresses:
  - below 0x10;
  - beyond the last configured bank;
  - window offsets 0x14 to 0x24;
  - byte addresses that are not word aligned.
- R8: `bus_rdata` is registered: it shows the selected word one clock edge after the address is presented. A write changes only the addressed bank. With no write, `pad_oe` and `pad_out` hold.
- R9: Every register reads back what it holds. The direction and output words return their stored bits. The set and clear words read as the current latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data or bit mask |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_oe | output | NUM_PINS | Pad output enable, 1 = drive |
| pad_out | output | NUM_PINS | Pad output value (the latch) |

## Verification
The checker takes for granted that reset is held for at least one edge before any access. It also assumes that bank 0 exists, with at least 32 configured pins. Its input-latency property assumes only that `pad_in` is sampled at clock edges, so the bench changes pads just after the falling edge, never on the active edge. Random accesses draw from all five registers of every bank, the unimplemented offsets, an out-of-range bank, addresses below the first window and misaligned addresses. Pad levels are held for three cycles before an input read is compared, except in the directed latency cases.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;

    localparam int ADDR_W      = 12;
    localparam int WORD_W      = 32;
    localparam int BANK_PINS   = 32;
    localparam int WIN_BASE    = 'h10;
    localparam int WIN_STRIDE  = 'h28;
    localparam int BANK_IDX_W  = 8;

    typedef enum logic [2:0] {
        SEL_DIR  = 3'd0,
        SEL_LAT  = 3'd1,
        SEL_SET  = 3'd2,
        SEL_CLR  = 3'd3,
        SEL_IN   = 3'd4,
        SEL_NONE = 3'd7
    } gpio_sel_e;

    typedef struct packed {
        logic                  hit;
        logic [BANK_IDX_W-1:0] bank;
        gpio_sel_e             sel;
    } gpio_dec_t;

    typedef struct packed {
        logic              we;
        gpio_sel_e         sel;
        logic [WORD_W-1:0] data;
    } gpio_cmd_t;

    function automatic int bank_pin_count(input int total, input int k);
        int left;
        left = total - k * BANK_PINS;
        if (left > BANK_PINS) return BANK_PINS;
        if (left < 0)         return 0;
        return left;
    endfunction

    function automatic gpio_sel_e word_to_sel(input int rel);
        case (rel)
            'h00:    return SEL_DIR;
            'h04:    return SEL_LAT;
            'h08:    return SEL_SET;
            'h0C:    return SEL_CLR;
            'h10:    return SEL_IN;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_BANKS = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_dec_t         dec
);
    localparam int LAST_ADDR = WIN_BASE + NUM_BANKS * WIN_STRIDE;

    always_comb begin
        int a;
        int off;
        int bk;
        int rel;
        gpio_sel_e s;
        a   = int'(addr);
        off = a - WIN_BASE;
        bk  = off / WIN_STRIDE;
        rel = off - bk * WIN_STRIDE;
        s   = word_to_sel(rel);
        dec.hit  = 1'b0;
        dec.bank = '0;
        dec.sel  = SEL_NONE;
        if (a >= WIN_BASE && a < LAST_ADDR && s != SEL_NONE) begin
            dec.hit  = 1'b1;
            dec.bank = BANK_IDX_W'(bk);
            dec.sel  = s;
        end
    end

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  gpio_cmd_t         cmd,
    input  gpio_sel_e         rd_sel,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [WORD_W-1:0] rd_word
);
    logic [PINS-1:0] dir_q;
    logic [PINS-1:0] lat_q;
    logic [PINS-1:0] in_sync;
    logic [PINS-1:0] mask;

    assign mask = cmd.data[PINS-1:0];

    gpio_sync2 #(.WIDTH(PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            lat_q <= '0;
        end else if (cmd.we) begin
            case (cmd.sel)
                SEL_DIR: dir_q <= mask;
                SEL_LAT: lat_q <= mask;
                SEL_SET: lat_q <= lat_q | mask;
                SEL_CLR: lat_q <= lat_q & ~mask;
                default: ;
            endcase
        end
    end

    assign pad_oe  = rst ? '0 : ~dir_q;
    assign pad_out = lat_q;

    always_comb begin
        logic [PINS-1:0] v;
        case (rd_sel)
            SEL_DIR:                   v = dir_q;
            SEL_LAT, SEL_SET, SEL_CLR: v = lat_q;
            SEL_IN:                    v = in_sync;
            default:                   v = '0;
        endcase
        rd_word = WORD_W'(v);
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 160
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [11:0]          bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]  pad_in,
    output logic [NUM_PINS-1:0]  pad_oe,
    output logic [NUM_PINS-1:0]  pad_out
);
    localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;

    gpio_dec_t         dec;
    logic [WORD_W-1:0] bank_rd [NUM_BANKS];
    logic [WORD_W-1:0] rd_next;

    gpio_addr_decode #(.NUM_BANKS(NUM_BANKS)) u_dec (
        .addr (bus_addr),
        .dec  (dec)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        localparam int PB = bank_pin_count(NUM_PINS, k);
        gpio_cmd_t cmd;
        gpio_sel_e rsel;

        always_comb begin
            logic mine;
            mine     = dec.hit && (int'(dec.bank) == k);
            cmd.we   = bus_wr && mine;
            cmd.sel  = dec.sel;
            cmd.data = bus_wdata;
            rsel     = mine ? dec.sel : SEL_NONE;
        end

        gpio_bank #(.PINS(PB)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .cmd     (cmd),
            .rd_sel  (rsel),
            .pad_in  (pad_in[k*BANK_PINS +: PB]),
            .pad_oe  (pad_oe[k*BANK_PINS +: PB]),
            .pad_out (pad_out[k*BANK_PINS +: PB]),
            .rd_word (bank_rd[k])
        );
    end

    always_comb begin
        rd_next = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            rd_next = rd_next | bank_rd[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
    end

endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_PINS = 160
) (
    input logic                clk,
    input logic                rst,
    input logic [11:0]         bus_addr,
    input logic                bus_wr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [31:0]         pad_in0,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out
);
    localparam int NUM_BANKS = (NUM_PINS + BANK_PINS - 1) / BANK_PINS;
    localparam logic [11:0] A_DIR0 = 12'(WIN_BASE);
    localparam logic [11:0] A_SET0 = 12'(WIN_BASE + 'h08);
    localparam logic [11:0] A_CLR0 = 12'(WIN_BASE + 'h0C);
    localparam logic [11:0] A_IN0  = 12'(WIN_BASE + 'h10);
    localparam logic [11:0] A_END  = 12'(WIN_BASE + NUM_BANKS * WIN_STRIDE);

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_outputs_chk: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_DIR0 && !rst) |-> pad_oe[31:0] == ~$past(bus_wdata));

    // R3
    set_mask_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_SET0 && !rst)
        |-> pad_out[31:0] == ($past(pad_out[31:0]) | $past(bus_wdata)));

    // R4
    clr_mask_chk: assert property (@(posedge clk) disable iff (rst)
        $past(bus_wr && bus_addr == A_CLR0 && !rst)
        |-> pad_out[31:0] == ($past(pad_out[31:0]) & ~$past(bus_wdata)));

    // R6
    input_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 3 && $past(bus_addr) == A_IN0) |-> bus_rdata == $past(pad_in0, 3));

    // R7
    outside_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_addr) >= A_END || $past(bus_addr) < A_DIR0) |-> bus_rdata == '0);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!bus_wr && !rst) |-> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in0   (pad_in[31:0]),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out)
);

// File: tb/test_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module test_gpio_bank_ctrl;
    localparam int NP = 160;
    localparam int NB = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_oe;
    logic [NP-1:0] pad_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] m_dir [NB];
    logic [31:0] m_lat [NB];

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP)) i_gpio_bank_ctrl (.*);

    task automatic check(input string req, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // decoded target: returns bank (or -1) and window offset
    function automatic int addr_bank(input int a);
        int off;
        if (a < 'h10 || (a % 4) != 0) return -1;
        off = a - 'h10;
        if (off / 'h28 >= NB) return -1;
        if ((off % 'h28) > 'h10) return -1;
        return off / 'h28;
    endfunction

    function automatic int addr_rel(input int a);
        return (a - 'h10) % 'h28;
    endfunction

    function automatic logic [31:0] exp_read(input int a);
        int b;
        b = addr_bank(a);
        if (b < 0) return '0;
        case (addr_rel(a))
            'h00: return m_dir[b];
            'h10: return pad_in[b*32 +: 32];
            default: return m_lat[b];
        endcase
    endfunction

    function automatic logic [NP-1:0] exp_oe();
        logic [NP-1:0] v;
        for (int b = 0; b < NB; b++) v[b*32 +: 32] = ~m_dir[b];
        return v;
    endfunction

    function automatic logic [NP-1:0] exp_out();
        logic [NP-1:0] v;
        for (int b = 0; b < NB; b++) v[b*32 +: 32] = m_lat[b];
        return v;
    endfunction

    task automatic model_write(input int a, input logic [31:0] d);
        int b;
        b = addr_bank(a);
        if (b < 0) return;
        case (addr_rel(a))
            'h00: m_dir[b] = d;
            'h04: m_lat[b] = d;
            'h08: m_lat[b] = m_lat[b] | d;
            'h0C: m_lat[b] = m_lat[b] & ~d;
            default: ;
        endcase
    endtask

    task automatic do_write(input int a, input logic [31:0] d, input string req);
        bus_addr  = 12'(a);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        check(req, "pad_oe after write", pad_oe, exp_oe());
        check(req, "pad_out after write", pad_out, exp_out());
    endtask

    task automatic do_read(input int a, input string req);
        logic [31:0] e;
        bus_addr = 12'(a);
        bus_wr   = 1'b0;
        e = exp_read(a);
        @(negedge clk);
        check(req, $sformatf("read %h", a), NP'(bus_rdata), NP'(e));
    endtask

    function automatic int reg_addr(input int b, input int rel);
        return 'h10 + 'h28 * b + rel;
    endfunction

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_dir[b] = '1;
            m_lat[b] = '0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state while reset is held
        check("R1", "pad_oe in reset", pad_oe, '0);
        check("R1", "pad_out in reset", pad_out, '0);
        check("R1", "rdata in reset", NP'(bus_rdata), '0);
        rst = 1'b0;
        @(negedge clk);
        for (int b = 0; b < NB; b++) do_read(reg_addr(b, 'h00), "R1 dir reset");
        do_read(reg_addr(4, 'h04), "R1 latch reset");

        // Directed: R2 direction, R5 whole write, R3/R4 masks
        do_write(reg_addr(0, 'h00), 32'h0000_FFFF, "R2");
        do_read(reg_addr(0, 'h00), "R2 readback");
        do_write(reg_addr(1, 'h04), 32'hA5A5_0F0F, "R5");
        do_read(reg_addr(1, 'h04), "R5 readback");
        do_write(reg_addr(1, 'h08), 32'h0000_00F0, "R3");
        do_write(reg_addr(1, 'h0C), 32'h0F00_000F, "R4");
        do_read(reg_addr(1, 'h08), "R9 set reads latch");
        do_read(reg_addr(1, 'h0C), "R9 clear reads latch");
        do_write(reg_addr(2, 'h08), 32'h0, "R3 zero mask");
        do_write(reg_addr(2, 'h0C), 32'h0, "R4 zero mask");

        // R7 ignored writes and zero reads
        do_write(reg_addr(0, 'h14), 32'hFFFF_FFFF, "R7 offset 0x14");
        do_write(reg_addr(NB, 'h00), 32'h0, "R7 bank beyond");
        do_write('h08, 32'h0, "R7 below base");
        do_write(reg_addr(2, 'h05), 32'hFFFF_FFFF, "R7 misaligned");
        do_read(reg_addr(0, 'h24), "R7 read 0x24");
        do_read(reg_addr(NB, 'h04), "R7 read beyond");
        do_read('h04, "R7 read below");

        // R6 latency and output-independence
        pad_in[31:0] = 32'h1234_5678;
        repeat (3) @(negedge clk);
        do_write(reg_addr(0, 'h04), 32'hFFFF_FFFF, "R6 drive latch");
        do_read(reg_addr(0, 'h10), "R6 reads pad not latch");
        pad_in[31:0] = 32'hCAFE_0001;
        bus_addr = 12'(reg_addr(0, 'h10));
        @(negedge clk);
        check("R6", "first read old level", NP'(bus_rdata), NP'(32'h1234_5678));
        @(negedge clk);
        check("R6", "second read old level", NP'(bus_rdata), NP'(32'h1234_5678));
        @(negedge clk);
        check("R6", "third read new level", NP'(bus_rdata), NP'(32'hCAFE_0001));

        // Constrained random mix
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            int b, rel, a, kind;
            kind = int'($urandom_range(0, 9));
            b    = int'($urandom_range(0, NB));
            rel  = 4 * int'($urandom_range(0, 9));
            a    = reg_addr(b, rel);
            if (kind == 9) a = a + 1;
            if (kind == 8) a = int'($urandom_range(0, 15));
            if (kind < 5) begin
                do_write(a, $urandom(), "R8 random write");
            end else if (kind == 5) begin
                for (int p = 0; p < NB; p++) pad_in[p*32 +: 32] = $urandom();
                repeat (3) @(negedge clk);
                do_read(reg_addr(b % NB, 'h10), "R6 random input");
            end else begin
                do_read(a, "R9 random read");
            end
        end
        check("R8", "final pad_oe", pad_oe, exp_oe());
        check("R8", "final pad_out", pad_out, exp_out());

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule